// File: doc/BRIEF.md
# Stacked Chip-Select Address Decoder

This block turns an address from the memory-mapped read path of a serial-flash controller into a device selection. Four chip selects sit behind one contiguous mapped region. Each select owns a window whose length is programmed in kilobytes, that is, the byte length shifted right by ten. No base address is ever programmed. The first window starts at address zero, and each later window starts where the one before it ends. The stacking order, from the lowest address upward, is A1, A2, B1, B2. A window programmed with size zero takes no space, so a single device can own the whole region while the other three sizes are zero.

For every access strobe, the block returns one registered result a cycle later. The result holds a one-hot chip select, the byte offset of the address inside the selected window, and an error flag. The error flag is set when the address lies past the end of the last window. The size inputs are copied into an internal shadow only while no access is in flight, so a size change during a stream of accesses cannot split that stream across two different maps.

Top module: `stacked_cs_decoder`

## Requirements
- R1: While reset is asserted, and after it is released with no access strobe, `rsp_valid_o`, `rsp_cs_o` and `rsp_err_o` are all zero.
- R2: An access strobe on `req_valid_i` in cycle N produces `rsp_valid_o` high in cycle N+1. A cycle with no strobe produces `rsp_valid_o` low in the cycle after it.
- R3: Chip-select bit 0 is A1, bit 1 is A2, bit 2 is B1 and bit 3 is B2. The windows are stacked in that bit order, starting from address 0.
- R4: Each size field, taken from `win_size_kb_i` with field i at bits [22*i+21:22*i], gives window i a span of exactly size×1024 bytes. The window's base is 1024 times the sum of all lower fields.
- R5: A window whose size is zero is never selected. Its base is shared with the next window up, and that next window gets the address.
- R6: When only one size is nonzero, that device is selected from address 0 up to its size×1024−1.
- R7: An address at or above 1024 times the sum of all four sizes gives `rsp_err_o`=1 and `rsp_cs_o`=0. This includes the case where all four sizes are zero.
- R8: `rsp_offset_o` equals the access address minus the base of the selected window. It is zero when the error flag is set.
- R9: `rsp_cs_o` never has more than one bit set.
- R10: The sizes used for decoding are taken from `win_size_kb_i` only in a cycle where both `req_valid_i` and `rsp_valid_o` are low. A size change during back-to-back accesses has no effect until such a cycle has occurred.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Access strobe |
| req_addr_i | input | 32 | Access address, relative to the base of the mapped region |
| win_size_kb_i | input | 88 | Four 22-bit window sizes in KB; field 0 is A1 and field 3 is B2 |
| rsp_valid_o | output | 1 | Result valid, one cycle after the strobe |
| rsp_cs_o | output | 4 | One-hot chip select; bit 0 is A1 and bit 3 is B2 |
| rsp_offset_o | output | 32 | Byte offset inside the selected window |
| rsp_err_o | output | 1 | The address lies beyond all windows |

## Verification
The decode is tried against four map patterns:
- **Four equal windows.** Addresses fall on the first and last byte of each window. This separates an off-by-one on a window boundary from a wrong stacking order.
- **Map with zero-size holes.** A zero-size window sits between nonzero ones, and the map ends on a zero-size window. This shows whether an empty window is skipped or wrongly claims its base.
- **Single owner.** Only one device has a nonzero size, and one case has all four sizes zero. These show that the base of the owner collapses to zero, and that the error flag covers a fully empty map.
- **Wide sizes.** The windows reach the top of the 32-bit space, and one window ends 1 KB short of it. These exercise the wide limit comparison.

A separate stream of back-to-back accesses changes the sizes in the middle of the stream. It tells a correctly held shadow from one that follows the inputs live.

// File: rtl/stacked_cs_pkg.sv
package stacked_cs_pkg;
  // Size fields are kilobyte counts: byte span = size << KB_SHIFT
  localparam int unsigned KB_SHIFT = 10;

  // Stacking order from the lowest address upward; the value is the cs bit
  typedef enum logic [1:0] {
    WIN_A1 = 2'd0,
    WIN_A2 = 2'd1,
    WIN_B1 = 2'd2,
    WIN_B2 = 2'd3
  } win_id_e;
endpackage

// File: rtl/cs_size_shadow.sv
module cs_size_shadow #(
  parameter int unsigned NUM_CS = 4,
  parameter int unsigned SIZE_W = 22
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load_en,
  input  logic [NUM_CS*SIZE_W-1:0] size_i,
  output logic [NUM_CS*SIZE_W-1:0] size_q
);
  logic [NUM_CS*SIZE_W-1:0] size_d;

  always_comb begin
    size_d = size_q;
    if (load_en) size_d = size_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) size_q <= '0;
    else        size_q <= size_d;
  end

  AST_SHADOW_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> $stable(size_q)); // R10
endmodule

// File: rtl/cs_window_map.sv
module cs_window_map #(
  parameter int unsigned NUM_CS = 4,
  parameter int unsigned SIZE_W = 22,
  parameter int unsigned LIM_W  = 35
) (
  input  logic [NUM_CS*SIZE_W-1:0]    size_kb_i,
  output logic [(NUM_CS+1)*LIM_W-1:0] bound_o
);
  import stacked_cs_pkg::*;

  localparam int unsigned PAD_W = LIM_W - SIZE_W - KB_SHIFT;

  // bound i is the base of window i; bound NUM_CS is the end of the map
  assign bound_o[LIM_W-1:0] = '0;

  for (genvar i = 0; i < NUM_CS; i++) begin : g_stack
    logic [LIM_W-1:0] span;
    assign span = {{PAD_W{1'b0}}, size_kb_i[i*SIZE_W +: SIZE_W], {KB_SHIFT{1'b0}}};
    assign bound_o[(i+1)*LIM_W +: LIM_W] = bound_o[i*LIM_W +: LIM_W] + span;
  end
endmodule

// File: rtl/cs_hit_decode.sv
module cs_hit_decode #(
  parameter int unsigned NUM_CS = 4,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LIM_W  = 35
) (
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [(NUM_CS+1)*LIM_W-1:0] bound_i,
  output logic [NUM_CS-1:0]           hit_o,
  output logic                        miss_o,
  output logic [ADDR_W-1:0]           offset_o
);
  localparam int unsigned CMP_W = (ADDR_W > LIM_W) ? ADDR_W : LIM_W;

  logic [CMP_W-1:0] addr_x;
  logic [CMP_W-1:0] lim_x [NUM_CS+1];
  logic [CMP_W-1:0] diff  [NUM_CS];

  assign addr_x = CMP_W'(addr_i);

  for (genvar b = 0; b <= NUM_CS; b++) begin : g_lim
    assign lim_x[b] = CMP_W'(bound_i[b*LIM_W +: LIM_W]);
  end

  // Empty windows have base == end and so can never hit
  for (genvar i = 0; i < NUM_CS; i++) begin : g_win
    assign hit_o[i] = (addr_x >= lim_x[i]) && (addr_x < lim_x[i+1]);
    assign diff[i]  = addr_x - lim_x[i];
  end

  assign miss_o = addr_x >= lim_x[NUM_CS];

  always_comb begin
    offset_o = '0;
    for (int i = 0; i < NUM_CS; i++) begin
      if (hit_o[i]) offset_o = offset_o | diff[i][ADDR_W-1:0];
    end
  end
endmodule

// File: rtl/stacked_cs_decoder.sv
module stacked_cs_decoder #(
  parameter int unsigned NUM_CS = 4,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned SIZE_W = 22
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid_i,
  input  logic [ADDR_W-1:0]        req_addr_i,
  input  logic [NUM_CS*SIZE_W-1:0] win_size_kb_i,
  output logic                     rsp_valid_o,
  output logic [NUM_CS-1:0]        rsp_cs_o,
  output logic [ADDR_W-1:0]        rsp_offset_o,
  output logic                     rsp_err_o
);
  import stacked_cs_pkg::*;

  localparam int unsigned LIM_W = SIZE_W + KB_SHIFT + $clog2(NUM_CS) + 1;

  logic [NUM_CS*SIZE_W-1:0]    size_q;
  logic [(NUM_CS+1)*LIM_W-1:0] bound;
  logic [NUM_CS-1:0]           hit;
  logic                        miss;
  logic [ADDR_W-1:0]           offset;
  logic                        shadow_load;

  logic                        valid_d;
  logic [NUM_CS-1:0]           cs_d;
  logic [ADDR_W-1:0]           offset_d;
  logic                        err_d;

  assign shadow_load = !req_valid_i && !rsp_valid_o;

  cs_size_shadow #(.NUM_CS(NUM_CS), .SIZE_W(SIZE_W)) u_shadow (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_en (shadow_load),
    .size_i  (win_size_kb_i),
    .size_q  (size_q)
  );

  cs_window_map #(.NUM_CS(NUM_CS), .SIZE_W(SIZE_W), .LIM_W(LIM_W)) u_map (
    .size_kb_i (size_q),
    .bound_o   (bound)
  );

  cs_hit_decode #(.NUM_CS(NUM_CS), .ADDR_W(ADDR_W), .LIM_W(LIM_W)) u_hit (
    .addr_i   (req_addr_i),
    .bound_i  (bound),
    .hit_o    (hit),
    .miss_o   (miss),
    .offset_o (offset)
  );

  always_comb begin
    valid_d  = req_valid_i;
    cs_d     = '0;
    offset_d = '0;
    err_d    = 1'b0;
    if (req_valid_i) begin
      cs_d  = hit;
      err_d = miss;
      if (!miss) offset_d = offset;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_o  <= 1'b0;
      rsp_cs_o     <= '0;
      rsp_offset_o <= '0;
      rsp_err_o    <= 1'b0;
    end else begin
      rsp_valid_o  <= valid_d;
      rsp_cs_o     <= cs_d;
      rsp_offset_o <= offset_d;
      rsp_err_o    <= err_d;
    end
  end

  AST_CS_ONEHOT:   assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rsp_cs_o)); // R9
  AST_REQ_TO_RSP:  assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_i |=> rsp_valid_o); // R2
  AST_IDLE_TO_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid_i |=> (!rsp_valid_o && rsp_cs_o == '0 && !rsp_err_o)); // R1
  AST_ERR_NO_CS:   assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err_o |-> (rsp_cs_o == '0 && rsp_offset_o == '0)); // R7
  AST_VALID_DECIDES: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o |-> ($countones(rsp_cs_o) + 32'(rsp_err_o) <= 1)); // R8
endmodule

// File: tb/tb_stacked_cs_decoder.sv
module tb_stacked_cs_decoder;
  localparam int NV = 16;

  typedef struct packed {
    logic [21:0] s0, s1, s2, s3;
    logic [31:0] addr;
    logic [3:0]  cs;
    logic [31:0] off;
    logic        err;
  } vec_t;

  // Expected values follow the requirements: base = 1024 * sum of lower sizes
  localparam vec_t TBL [NV] = '{
    '{22'd4, 22'd4, 22'd4, 22'd4, 32'h0000_0000, 4'b0001, 32'h0000_0000, 1'b0}, // R3 A1 first byte
    '{22'd4, 22'd4, 22'd4, 22'd4, 32'h0000_0FFF, 4'b0001, 32'h0000_0FFF, 1'b0}, // R4 A1 last byte
    '{22'd4, 22'd4, 22'd4, 22'd4, 32'h0000_1000, 4'b0010, 32'h0000_0000, 1'b0}, // R3 A2 base
    '{22'd4, 22'd4, 22'd4, 22'd4, 32'h0000_2010, 4'b0100, 32'h0000_0010, 1'b0}, // R8 B1 offset
    '{22'd4, 22'd4, 22'd4, 22'd4, 32'h0000_3FFF, 4'b1000, 32'h0000_0FFF, 1'b0}, // R3 B2 last byte
    '{22'd4, 22'd4, 22'd4, 22'd4, 32'h0000_4000, 4'b0000, 32'h0000_0000, 1'b1}, // R7 first byte past end
    '{22'd1, 22'd0, 22'd2, 22'd0, 32'h0000_0400, 4'b0100, 32'h0000_0000, 1'b0}, // R5 A2 empty, B1 takes base
    '{22'd1, 22'd0, 22'd2, 22'd0, 32'h0000_0C00, 4'b0000, 32'h0000_0000, 1'b1}, // R5 B2 empty -> miss
    '{22'd0, 22'd0, 22'd8, 22'd0, 32'h0000_0000, 4'b0100, 32'h0000_0000, 1'b0}, // R6 lone owner at 0
    '{22'd0, 22'd0, 22'd8, 22'd0, 32'h0000_1FFF, 4'b0100, 32'h0000_1FFF, 1'b0}, // R6 lone owner last
    '{22'd0, 22'd0, 22'd0, 22'd0, 32'h0000_0000, 4'b0000, 32'h0000_0000, 1'b1}, // R7 empty map
    '{22'd3, 22'd5, 22'd0, 22'd7, 32'h0000_2000, 4'b1000, 32'h0000_0000, 1'b0}, // R4 uneven sizes
    '{22'd3, 22'd5, 22'd0, 22'd7, 32'h0000_1FFF, 4'b0010, 32'h0000_13FF, 1'b0}, // R8 uneven offset
    '{22'h200000, 22'h200000, 22'd0, 22'd0, 32'h8000_0004, 4'b0010, 32'h0000_0004, 1'b0}, // R4 wide
    '{22'h200000, 22'h200000, 22'd0, 22'd0, 32'hFFFF_FFFF, 4'b0010, 32'h7FFF_FFFF, 1'b0}, // R4 top byte
    '{22'h3FFFFF, 22'd0, 22'd0, 22'd0, 32'hFFFF_FC00, 4'b0000, 32'h0000_0000, 1'b1}  // R7 wide miss
  };

  logic        clk;
  logic        rst_n;
  logic        req_valid_i;
  logic [31:0] req_addr_i;
  logic [87:0] win_size_kb_i;
  logic        rsp_valid_o;
  logic [3:0]  rsp_cs_o;
  logic [31:0] rsp_offset_o;
  logic        rsp_err_o;

  int checks;
  int errors;
  bit done;

  stacked_cs_decoder dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid_i   (req_valid_i),
    .req_addr_i    (req_addr_i),
    .win_size_kb_i (win_size_kb_i),
    .rsp_valid_o   (rsp_valid_o),
    .rsp_cs_o      (rsp_cs_o),
    .rsp_offset_o  (rsp_offset_o),
    .rsp_err_o     (rsp_err_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_rsp(input string req, input logic [3:0] cs, input logic [31:0] off,
                         input logic err);
    chk({req, " valid"}, 64'(rsp_valid_o), 64'd1);
    chk({req, " cs"}, 64'(rsp_cs_o), 64'(cs));
    chk({req, " offset"}, 64'(rsp_offset_o), 64'(off));
    chk({req, " err"}, 64'(rsp_err_o), 64'(err));
    chk("R9 one-hot", 64'($countones(rsp_cs_o) <= 1), 64'd1);
  endtask

  task automatic idle(input int n);
    req_valid_i = 1'b0;
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    checks = 0;
    errors = 0;
    done = 1'b0;
    rst_n = 1'b0;
    req_valid_i = 1'b0;
    req_addr_i = '0;
    win_size_kb_i = '0;
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", 64'(rsp_valid_o), 64'd0);
    chk("R1 cs in reset", 64'(rsp_cs_o), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid after release", 64'(rsp_valid_o), 64'd0);
    chk("R1 err after release", 64'(rsp_err_o), 64'd0);

    for (int v = 0; v < NV; v++) begin
      win_size_kb_i = {TBL[v].s3, TBL[v].s2, TBL[v].s1, TBL[v].s0};
      idle(3);
      req_addr_i = TBL[v].addr;
      req_valid_i = 1'b1;
      @(negedge clk);
      req_valid_i = 1'b0;
      chk_rsp($sformatf("table vector %0d", v), TBL[v].cs, TBL[v].off, TBL[v].err);
      @(negedge clk);
      chk("R2 no strobe -> no result", 64'(rsp_valid_o), 64'd0);
    end

    // R10: sizes change during a stream; the stream keeps the old map
    win_size_kb_i = {22'd4, 22'd4, 22'd4, 22'd4};
    idle(3);
    req_addr_i = 32'h0000_1000;
    req_valid_i = 1'b1;
    win_size_kb_i = {22'd0, 22'd0, 22'd0, 22'd8};
    @(negedge clk);
    chk_rsp("R10 stream beat 0", 4'b0010, 32'h0, 1'b0);
    @(negedge clk);
    chk_rsp("R10 stream beat 1", 4'b0010, 32'h0, 1'b0);
    req_valid_i = 1'b0;
    @(negedge clk);
    chk("R2 valid drops after stream", 64'(rsp_valid_o), 64'd0);
    @(negedge clk);
    req_valid_i = 1'b1;
    @(negedge clk);
    req_valid_i = 1'b0;
    chk_rsp("R10 new map after idle", 4'b0001, 32'h0000_1000, 1'b0);

    // R2: back-to-back strobes give one result per cycle
    idle(3);
    req_valid_i = 1'b1;
    req_addr_i = 32'h0000_0000;
    @(negedge clk);
    req_addr_i = 32'h0000_2000;
    chk_rsp("R2 back-to-back first", 4'b0001, 32'h0, 1'b0);
    @(negedge clk);
    req_valid_i = 1'b0;
    chk_rsp("R2 back-to-back second", 4'b0000, 32'h0, 1'b1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule